// File: doc/BRIEF.md
# Lookahead Algebraic Decoder for a Rate-1/3 Convolutional Stream

This block recovers data words protected by a rate-1/3 convolutional code with two memory cells. The encoder emits one three-bit symbol per data bit. Its three bits are `x = d[n]^d[n-1]^d[n-2]`, `y = d[n]^d[n-2]` and `z = d[n]^d[n-1]`, and each word is closed with two zero tail bits. The encoder memory is cleared to 00 at the start of every word. The decoder returns one corrected data bit per accepted symbol once its lookahead window is full.

For every position the decoder forms three algebraic estimates of the data bit. Each estimate combines one received bit with the bits already decided. Each candidate value for the current bit and the next two bits is scored by how many estimates it contradicts across the current symbol and the two symbols after it. The lowest score wins, and ties go to the lowest candidate index. This catches a corrupted x, y or z bit, and also two corrupted x bits in a row, which look clean one step later. The decided bits, not the raw estimates, feed the history used by later estimates. A flag marks every output bit whose three estimates did not all agree.

Both stream edges use valid/ready. An input symbol is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a decided bit waits in the output register with `out_ready` low. An output bit stays stable until it is taken. Valid may be raised at any time and does not depend on ready.

Top module: `lac_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For an error-free word every output bit equals the encoded data bit and `out_fix` is 0. Input bit 2 of `in_sym` is x, bit 1 is y and bit 0 is z.
- R3: A single corrupted x bit at a data position is corrected, and `out_fix` is 1 for that bit only.
- R4: A single corrupted y bit at a data position is corrected, and `out_fix` is 1 for that bit only. This includes the first bit of the word.
- R5: A single corrupted z bit at a data position is corrected, and `out_fix` is 1 for that bit only. This includes the last data bit.
- R6: The x bits of two consecutive data positions corrupted together are both corrected, and `out_fix` is 1 for those two bits.
- R7: A word is WORD_BITS data symbols followed by two tail symbols, with `in_sow` high on the first. Exactly WORD_BITS bits are output, in order. The tail symbols produce no output. Bit 0 becomes valid in the cycle after the word's third symbol is accepted.
- R8: Symbols accepted with `in_sow` low are consumed without output in two cases: before any start-of-word has been seen since reset, and after all WORD_BITS+2 symbols of a word.
- R9: A symbol with `in_sow` high starts a new word at any point. The history restarts from 00, so a truncated word followed by a new word still decodes the new word correctly.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_fix` hold their values and `in_ready` is 0.
- R11: Idle cycles on the input (`in_valid` low) do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Decoder can take a symbol |
| in_sym | input | 3 | Received symbol: bit 2 x, bit 1 y, bit 0 z |
| in_sow | input | 1 | Symbol is the first of a word |
| out_valid | output | 1 | Decoded bit present |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded data bit |
| out_fix | output | 1 | Estimates for this bit disagreed |

## Verification
The decider's history is fed back from its own decisions. A wrong history bit therefore does not stay local. It corrupts the estimates of the next two positions, and on a clean word it shows at the ports as a raised `out_fix` or a wrong `out_bit` within two outputs. Errors in the symbol counter show in the number of bits per word, or in the cycle the first bit appears, both of which the bench measures against the count of accepted symbols. A window that shifts in the wrong order only shows up when errors are present. The injected x, y, z and double-x cases then return a wrong bit at the corrupted position or one of its two neighbours.

// File: rtl/lac_pkg.sv
package lac_pkg;
  // Symbol layout on the wire: bit 2 = x, bit 1 = y, bit 0 = z.
  localparam int SYM_W = 3;

  // Three estimates of the data bit at one step, ordered {from x, from y, from z},
  // given the two preceding data bits h1 = d[n-1] and h2 = d[n-2].
  function automatic logic [2:0] est3(input logic [2:0] s, input logic h1, input logic h2);
    est3 = {s[2] ^ h1 ^ h2, s[1] ^ h2, s[0] ^ h1};
  endfunction
endpackage

// File: rtl/lac_hyp_cost.sv
module lac_hyp_cost
  import lac_pkg::*;
#(
  parameter int LOOK = 2,
  localparam int WIN = LOOK + 1,
  localparam int CW  = $clog2(3 * WIN + 1)
) (
  input  logic [SYM_W*WIN-1:0] win,
  input  logic                 d1,
  input  logic                 d2,
  input  logic [WIN-1:0]       hyp,
  output logic [CW-1:0]        cost
);
  logic       h1, h2;
  logic [2:0] e;

  // Count estimates that contradict the hypothesised bit at each step,
  // rolling the hypothesis itself into the history of later steps.
  always_comb begin
    h1   = d1;
    h2   = d2;
    cost = '0;
    e    = '0;
    for (int j = 0; j < WIN; j++) begin
      e = est3(win[SYM_W*j +: SYM_W], h1, h2);
      for (int b = 0; b < 3; b++) begin
        if (e[b] != hyp[j]) cost = cost + CW'(1);
      end
      h2 = h1;
      h1 = hyp[j];
    end
  end
endmodule

// File: rtl/lac_argmin.sv
module lac_argmin #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*CW-1:0] costs,
  output logic [IW-1:0]   sel
);
  logic [CW-1:0] best;

  // Strict less-than keeps the lowest index on ties.
  always_comb begin
    best = costs[0 +: CW];
    sel  = '0;
    for (int i = 1; i < N; i++) begin
      if (costs[i*CW +: CW] < best) begin
        best = costs[i*CW +: CW];
        sel  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lac_decoder.sv
module lac_decoder
  import lac_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int LOOK      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [2:0] in_sym,
  input  logic       in_sow,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit,
  output logic       out_fix
);
  localparam int WIN = LOOK + 1;
  localparam int NH  = 1 << WIN;
  localparam int CW  = $clog2(3 * WIN + 1);
  localparam int HW  = $clog2(NH);
  localparam int TOT = WORD_BITS + 2;
  localparam int IW  = $clog2(TOT + 1);

  // Older symbols of the window; slot 0 is the step being decided.
  logic [SYM_W*LOOK-1:0] hold_q;
  logic [SYM_W*WIN-1:0]  win;
  logic [IW-1:0]         cnt_q;
  logic                  d1_q, d2_q;
  logic                  accept, decide;
  logic [NH*CW-1:0]      costs;
  logic [HW-1:0]         sel;
  logic [2:0]            e0;
  logic                  agree;

  assign win      = {in_sym, hold_q};
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign decide   = accept && !in_sow &&
                    (cnt_q >= IW'(LOOK)) && (cnt_q < IW'(LOOK + WORD_BITS));

  assign e0    = est3(hold_q[0 +: SYM_W], d1_q, d2_q);
  assign agree = (e0[2] == e0[1]) && (e0[1] == e0[0]);

  for (genvar h = 0; h < NH; h++) begin : g_hyp
    lac_hyp_cost #(.LOOK(LOOK)) u_cost (
      .win  (win),
      .d1   (d1_q),
      .d2   (d2_q),
      .hyp  (WIN'(h)),
      .cost (costs[h*CW +: CW])
    );
  end

  lac_argmin #(.N(NH), .CW(CW)) u_pick (
    .costs (costs),
    .sel   (sel)
  );

  // Window shift and word position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= IW'(TOT);
    end else if (accept) begin
      hold_q <= win[SYM_W*WIN-1:SYM_W];
      if (in_sow)              cnt_q <= IW'(1);
      else if (cnt_q < IW'(TOT)) cnt_q <= cnt_q + IW'(1);
    end
  end

  // Decided-bit history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= 1'b0;
      d2_q <= 1'b0;
    end else if (accept && in_sow) begin
      d1_q <= 1'b0;
      d2_q <= 1'b0;
    end else if (decide) begin
      d2_q <= d1_q;
      d1_q <= sel[0];
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_fix   <= 1'b0;
    end else if (decide) begin
      out_valid <= 1'b1;
      out_bit   <= sel[0];
      out_fix   <= !agree;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_fix));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_agree: assert property (@(posedge clk) disable iff (!rst_n)
    decide && agree |=> out_bit == $past(e0[0]) && !out_fix);

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_sow && cnt_q == IW'(TOT) |=> !out_valid);

  a_r7_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  for (genvar h = 0; h < NH; h++) begin : g_chk
    a_r6_min_cost: assert property (@(posedge clk) disable iff (!rst_n)
      decide |-> costs[sel*CW +: CW] <= costs[h*CW +: CW]);
  end
endmodule

// File: tb/lac_decoder_tb.sv
module lac_decoder_tb;
  localparam int WB  = 16;
  localparam int TOT = WB + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_sym = '0;
  logic       in_sow = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_bit;
  logic       out_fix;

  lac_decoder #(.WORD_BITS(WB), .LOOK(2)) u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_sym, .in_sow,
    .out_valid, .out_ready, .out_bit, .out_fix
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [2:0] s_tri [0:63];
  logic       s_sow [0:63];
  int         s_len;
  logic       r_bit [0:63];
  logic       r_fix [0:63];
  int         r_n;
  bit         gaps = 0;
  bit         stalls = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enc_word(input logic [WB-1:0] d, input int base);
    logic a1, a2, b;
    a1 = 1'b0;
    a2 = 1'b0;
    for (int i = 0; i < TOT; i++) begin
      b = (i < WB) ? d[i] : 1'b0;
      s_tri[base+i] = {b ^ a1 ^ a2, b ^ a2, b ^ a1};
      s_sow[base+i] = (i == 0);
      a2 = a1;
      a1 = b;
    end
    s_len = base + TOT;
  endtask

  task automatic run();
    int  idx, cyc, drain;
    bit  held;
    logic pb, pf;
    idx = 0; cyc = 0; drain = 0; r_n = 0; held = 0; pb = 0; pf = 0;
    while (idx < s_len || drain < 4) begin
      @(negedge clk);
      cyc++;
      out_ready = !(stalls && (cyc % 4 == 2));
      if (idx < s_len && !(gaps && (cyc % 3 == 1))) begin
        in_valid = 1'b1;
        in_sym   = s_tri[idx];
        in_sow   = s_sow[idx];
      end else begin
        in_valid = 1'b0;
        in_sow   = 1'b0;
      end
      #1;
      if (held) chk(out_valid && out_bit == pb && out_fix == pf, "R10 held output", int'(out_bit), int'(pb));
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R10 in_ready during stall", int'(in_ready), 0);
        held = 1; pb = out_bit; pf = out_fix;
      end else held = 0;
      if (out_valid && out_ready && r_n < 64) begin
        r_bit[r_n] = out_bit;
        r_fix[r_n] = out_fix;
        r_n++;
      end
      if (in_valid && in_ready) idx++;
      else if (idx >= s_len) drain++;
      if (cyc > 3000) begin
        chk(0, "run stuck", idx, s_len);
        break;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sow = 1'b0; out_ready = 1'b1;
  endtask

  task automatic check_word(input string req, input int off, input logic [WB-1:0] d, input logic [WB-1:0] fix);
    for (int i = 0; i < WB; i++) begin
      chk(r_bit[off+i] == d[i], $sformatf("%s bit %0d", req, i), int'(r_bit[off+i]), int'(d[i]));
      chk(r_fix[off+i] == fix[i], $sformatf("%s flag %0d", req, i), int'(r_fix[off+i]), int'(fix[i]));
    end
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_presow();
    for (int i = 0; i < 4; i++) begin s_tri[i] = 3'b111; s_sow[i] = 1'b0; end
    s_len = 4;
    run();
    chk(r_n == 0, "R8 before first word", r_n, 0);
  endtask

  task automatic t_clean();
    enc_word(16'hB5C3, 0);
    run();
    chk(r_n == WB, "R7 bits per word", r_n, WB);
    check_word("R2 clean", 0, 16'hB5C3, 16'h0000);
    for (int i = 0; i < 3; i++) begin s_tri[i] = 3'b101; s_sow[i] = 1'b0; end
    s_len = 3;
    run();
    chk(r_n == 0, "R8 after word end", r_n, 0);
  endtask

  task automatic t_latency();
    enc_word(16'h0001, 0);
    @(negedge clk);
    in_valid = 1'b1; in_sym = s_tri[0]; in_sow = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R7 no output after symbol 0", int'(out_valid), 0);
    in_sym = s_tri[1]; in_sow = 1'b0;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R7 no output after symbol 1", int'(out_valid), 0);
    in_sym = s_tri[2];
    @(negedge clk); #1;
    chk(out_valid == 1'b1, "R7 valid after symbol 2", int'(out_valid), 1);
    chk(out_bit == 1'b1, "R7 first bit", int'(out_bit), 1);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_xerr();
    enc_word(16'h6A3D, 0);
    s_tri[3] ^= 3'b100;
    s_tri[9] ^= 3'b100;
    run();
    chk(r_n == WB, "R3 count", r_n, WB);
    check_word("R3 x error", 0, 16'h6A3D, 16'h0208);
  endtask

  task automatic t_yerr();
    enc_word(16'hE719, 0);
    s_tri[0]  ^= 3'b010;
    s_tri[12] ^= 3'b010;
    run();
    chk(r_n == WB, "R4 count", r_n, WB);
    check_word("R4 y error", 0, 16'hE719, 16'h1001);
  endtask

  task automatic t_zerr();
    enc_word(16'h8D52, 0);
    s_tri[6]  ^= 3'b001;
    s_tri[15] ^= 3'b001;
    run();
    chk(r_n == WB, "R5 count", r_n, WB);
    check_word("R5 z error", 0, 16'h8D52, 16'h8040);
  endtask

  task automatic t_xx();
    enc_word(16'h4BE6, 0);
    s_tri[5]  ^= 3'b100;
    s_tri[6]  ^= 3'b100;
    s_tri[12] ^= 3'b100;
    s_tri[13] ^= 3'b100;
    run();
    chk(r_n == WB, "R6 count", r_n, WB);
    check_word("R6 double x", 0, 16'h4BE6, 16'h3060);
  endtask

  task automatic t_restart();
    enc_word(16'h0F0F, 0);
    enc_word(16'hC3A5, 7);
    run();
    chk(r_n == 5 + WB, "R9 output count", r_n, 5 + WB);
    for (int i = 0; i < 5; i++)
      chk(r_bit[i] == (16'h0F0F >> i) % 2, $sformatf("R9 truncated bit %0d", i), int'(r_bit[i]), int'((16'h0F0F >> i) % 2));
    check_word("R9 new word", 5, 16'hC3A5, 16'h0000);
  endtask

  task automatic t_flow();
    enc_word(16'h9E27, 0);
    s_tri[7] ^= 3'b010;
    gaps = 1; stalls = 1;
    run();
    gaps = 0; stalls = 0;
    chk(r_n == WB, "R11 count with gaps", r_n, WB);
    check_word("R11 gaps and stalls", 0, 16'h9E27, 16'h0080);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_presow();
    t_clean();
    t_latency();
    t_xerr();
    t_yerr();
    t_zerr();
    t_xx();
    t_restart();
    t_flow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule